// File: doc/BRIEF.md
# Asymmetric SCL Timing Generator

This block turns a fast system clock into the SCL waveform of an I2C master, together with the strobes that tell a byte engine when to move SDA and when to read it. The low and the high part of each SCL period are set independently from one 32-bit divider word. Each is counted in units of eight system clocks, with an implicit +1, so a count of zero still gives a phase of eight clocks.

The byte engine issues one command at a time: open the bus (START), clock one data bit, re-open the bus while it is held (repeated START), or close it (STOP). The block shapes SCL and SDA for each command itself. It pulses a completion strobe when the command ends, and after that strobe it accepts the next command. The high phase counts only while the sensed SCL line is high, so a slow device that holds the clock low stretches the bit. Divider values are computed elsewhere. This block only takes the divider word at the start of each command and holds it there.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset and whenever the bus is idle, scl_o and sda_o are both 1 (released), the two strobes and done_o are 0, and the phase counter stays at zero.
- R2: Bits 15:0 of the divider word are the low count LO, and a low phase lasts exactly (LO+1)*8 clocks, from the edge that accepts a command to the edge that raises scl_o.
- R3: Bits 31:16 of the divider word are the high count HI, and the high phase of a data bit lasts exactly (HI+1)*8 clocks when nothing stretches it.
- R4: sda_chg_o pulses once in each low phase, (LO+1)*4 clocks after that phase starts. In the same cycle sda_o takes its new value: the command's bit for a data bit, 1 for a repeated START, 0 for a STOP. During a data bit, SDA never changes while SCL is high.
- R5: sda_smp_o pulses once per data bit, (HI+1)*4 counted high clocks after scl_o rises, and never together with sda_chg_o.
- R6: Command encoding: cmd_op_i = 0 START, 1 BIT, 2 RESTART, 3 STOP. A START taken in the idle state drops sda_o on the accepting edge, keeps scl_o high for (HI+1)*8 clocks, and then drops scl_o.
- R7: A RESTART releases SDA in the middle of the low phase, keeps SCL high for 2*(HI+1)*8 clocks, drops SDA (HI+1)*7 clocks after SCL rises, and then drops SCL.
- R8: A STOP drives SDA low in the middle of the low phase, keeps SCL high for (HI+1)*8 clocks, then releases SDA and returns to idle with SCL left high.
- R9: The divider word is captured only on the edge that accepts a command. A change to div_word_i while a command runs does not affect that command, and the next command uses the new word.
- R10: During a high phase the counter advances only in cycles in which scl_in_i reads 1. Each clock that scl_in_i is held low lengthens the high phase and delays the sample strobe by one clock.
- R11: Commands that arrive while a command runs are ignored, and so are commands the state does not allow (anything but START while idle, START while the bus is held). An ignored command causes no output change and no done_o.
- R12: done_o is a one-clock pulse, once per accepted command, on the edge that ends its last phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_word_i | input | 32 | High count in 31:16, low count in 15:0 |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 2 | Command code (0 START, 1 BIT, 2 RESTART, 3 STOP) |
| cmd_bit_i | input | 1 | Data bit to put on SDA for a BIT command |
| scl_in_i | input | 1 | Sensed level of the SCL line |
| scl_o | output | 1 | SCL level to drive (1 = released) |
| sda_o | output | 1 | SDA level to drive (1 = released) |
| sda_chg_o | output | 1 | Strobe in the middle of the low phase |
| sda_smp_o | output | 1 | Strobe in the middle of a data bit's high phase |
| done_o | output | 1 | One-clock pulse when a command completes |

## Verification
The bench uses low and high counts that differ from each other, so a design that swapped the two 16-bit fields, dropped the implicit +1 or used a unit other than eight clocks would show the wrong phase lengths. It rewrites the divider in the middle of a bit, to catch a design that loads the word on every cycle and cuts the running phase short. It holds SCL low from outside, to catch a design whose high counter runs freely and gives a short high time against a slow device. It also checks the repeated-START points at 7/8 and 2x of the high period, the SDA release at the end of STOP, and commands sent while busy or in the wrong state, which a careless design would act on.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    typedef enum logic [1:0] {
        OP_START   = 2'd0,
        OP_BIT     = 2'd1,
        OP_RESTART = 2'd2,
        OP_STOP    = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HELD  = 3'd1,
        ST_START = 3'd2,
        ST_LOW   = 3'd3,
        ST_HIGH  = 3'd4
    } st_e;

    typedef struct packed {
        st_e  st;
        op_e  op;
        logic bitv;
        logic scl;
        logic sda;
        logic chg;
        logic smp;
        logic done;
    } fsm_regs_t;

endpackage

// File: rtl/sclgen_divreg.sv
module sclgen_divreg #(
    parameter int CNT_W    = 16,
    parameter int PRE_LOG2 = 3,
    localparam int LEN_W   = CNT_W + PRE_LOG2 + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [2*CNT_W-1:0]   div_word_i,
    output logic [LEN_W-1:0]     lo_len_o,
    output logic [LEN_W-1:0]     lo_half_o,
    output logic [LEN_W-1:0]     hi_len_o,
    output logic [LEN_W-1:0]     hi_half_o,
    output logic [LEN_W-1:0]     hi_seven_o,
    output logic [LEN_W-1:0]     hi_double_o
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] hi;
    } div_regs_t;

    div_regs_t div_d, div_q;

    generate
        if (PRE_LOG2 < 3) begin : g_bad_prescale
            $error("PRE_LOG2 must be at least 3 for the 7/8 point");
        end
    endgenerate

    // Capture only on command acceptance (a period boundary).
    always_comb begin
        div_d = div_q;
        if (load_i) begin
            div_d.lo = div_word_i[CNT_W-1:0];
            div_d.hi = div_word_i[2*CNT_W-1:CNT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    logic [LEN_W-1:0] lo_plus1, hi_plus1;

    always_comb begin
        lo_plus1    = LEN_W'(div_q.lo) + ONE;
        hi_plus1    = LEN_W'(div_q.hi) + ONE;
        lo_len_o    = lo_plus1 << PRE_LOG2;
        hi_len_o    = hi_plus1 << PRE_LOG2;
        lo_half_o   = lo_len_o >> 1;
        hi_half_o   = hi_len_o >> 1;
        hi_seven_o  = hi_len_o - (hi_len_o >> 3);
        hi_double_o = hi_len_o << 1;
    end

endmodule

// File: rtl/sclgen_phase_cnt.sv
module sclgen_phase_cnt #(
    parameter int LEN_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    output logic [LEN_W-1:0] cnt_o
);
    logic [LEN_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)     cnt_d = '0;
        else if (en_i) cnt_d = cnt_q + LEN_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/sclgen_fsm.sv
module sclgen_fsm
    import sclgen_pkg::*;
#(
    parameter int LEN_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid_i,
    input  logic [1:0]       cmd_op_i,
    input  logic             cmd_bit_i,
    input  logic             scl_in_i,
    input  logic [LEN_W-1:0] cnt_i,
    input  logic [LEN_W-1:0] lo_len_i,
    input  logic [LEN_W-1:0] lo_half_i,
    input  logic [LEN_W-1:0] hi_len_i,
    input  logic [LEN_W-1:0] hi_half_i,
    input  logic [LEN_W-1:0] hi_seven_i,
    input  logic [LEN_W-1:0] hi_double_i,
    output logic             accept_o,
    output logic             cnt_clr_o,
    output logic             cnt_en_o,
    output logic             scl_o,
    output logic             sda_o,
    output logic             chg_o,
    output logic             smp_o,
    output logic             done_o
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    fsm_regs_t r_d, r_q;
    op_e       cmd_op;
    logic [LEN_W-1:0] hi_end;

    assign cmd_op = op_e'(cmd_op_i);
    assign hi_end = (r_q.op == OP_RESTART) ? hi_double_i : hi_len_i;

    always_comb begin
        r_d       = r_q;
        r_d.chg   = 1'b0;
        r_d.smp   = 1'b0;
        r_d.done  = 1'b0;
        accept_o  = 1'b0;
        cnt_clr_o = 1'b0;
        cnt_en_o  = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                cnt_clr_o = 1'b1;
                if (cmd_valid_i && cmd_op == OP_START) begin
                    accept_o = 1'b1;
                    r_d.st   = ST_START;
                    r_d.op   = OP_START;
                    r_d.sda  = 1'b0;
                end
            end
            ST_HELD: begin
                cnt_clr_o = 1'b1;
                if (cmd_valid_i && cmd_op != OP_START) begin
                    accept_o = 1'b1;
                    r_d.st   = ST_LOW;
                    r_d.op   = cmd_op;
                    r_d.bitv = cmd_bit_i;
                end
            end
            ST_START: begin
                cnt_en_o = scl_in_i;
                if (scl_in_i && cnt_i == hi_len_i - ONE) begin
                    cnt_clr_o = 1'b1;
                    r_d.st    = ST_HELD;
                    r_d.scl   = 1'b0;
                    r_d.done  = 1'b1;
                end
            end
            ST_LOW: begin
                cnt_en_o = 1'b1;
                if (cnt_i == lo_half_i - ONE) begin
                    r_d.chg = 1'b1;
                    case (r_q.op)
                        OP_BIT:     r_d.sda = r_q.bitv;
                        OP_RESTART: r_d.sda = 1'b1;
                        default:    r_d.sda = 1'b0;
                    endcase
                end
                if (cnt_i == lo_len_i - ONE) begin
                    cnt_clr_o = 1'b1;
                    r_d.st    = ST_HIGH;
                    r_d.scl   = 1'b1;
                end
            end
            ST_HIGH: begin
                cnt_en_o = scl_in_i;
                if (scl_in_i) begin
                    if (r_q.op == OP_BIT && cnt_i == hi_half_i - ONE)
                        r_d.smp = 1'b1;
                    if (r_q.op == OP_RESTART && cnt_i == hi_seven_i - ONE)
                        r_d.sda = 1'b0;
                    if (cnt_i == hi_end - ONE) begin
                        cnt_clr_o = 1'b1;
                        r_d.done  = 1'b1;
                        if (r_q.op == OP_STOP) begin
                            r_d.st  = ST_IDLE;
                            r_d.sda = 1'b1;
                        end else begin
                            r_d.st  = ST_HELD;
                            r_d.scl = 1'b0;
                        end
                    end
                end
            end
            default: begin
                cnt_clr_o = 1'b1;
                r_d.st    = ST_IDLE;
                r_d.scl   = 1'b1;
                r_d.sda   = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.op   <= OP_START;
            r_q.scl  <= 1'b1;
            r_q.sda  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_o  = r_q.scl;
    assign sda_o  = r_q.sda;
    assign chg_o  = r_q.chg;
    assign smp_o  = r_q.smp;
    assign done_o = r_q.done;

    // R1: idle means both lines released and the counter parked at zero
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> (r_q.scl && r_q.sda && cnt_i == '0));

    // R2: the low counter never runs past the programmed low length
    assert_low_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LOW) |-> (cnt_i < lo_len_i));

    // R3: the high counter of a bit or STOP stays within the high length
    assert_high_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HIGH && r_q.op != OP_RESTART) |-> (cnt_i < hi_len_i));

    // R4: during a data bit SDA moves only while SCL is low
    assert_sda_steady_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.scl && $past(r_q.scl) && r_q.sda != $past(r_q.sda)) |-> (r_q.op != OP_BIT));

    // R5: change and sample strobes are never together
    assert_strobes_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.chg && r_q.smp));

    // R10: a held-low SCL freezes the high counter
    assert_stretch_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HIGH && !scl_in_i) |=> $stable(cnt_i));

    // R12: completion is a single-cycle pulse
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
    parameter int CNT_W    = 16,
    parameter int PRE_LOG2 = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*CNT_W-1:0] div_word_i,
    input  logic               cmd_valid_i,
    input  logic [1:0]         cmd_op_i,
    input  logic               cmd_bit_i,
    input  logic               scl_in_i,
    output logic               scl_o,
    output logic               sda_o,
    output logic               sda_chg_o,
    output logic               sda_smp_o,
    output logic               done_o
);
    localparam int LEN_W = CNT_W + PRE_LOG2 + 2;

    logic             accept, cnt_clr, cnt_en;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] lo_len, lo_half, hi_len, hi_half, hi_seven, hi_double;

    sclgen_divreg #(.CNT_W(CNT_W), .PRE_LOG2(PRE_LOG2)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .div_word_i  (div_word_i),
        .lo_len_o    (lo_len),
        .lo_half_o   (lo_half),
        .hi_len_o    (hi_len),
        .hi_half_o   (hi_half),
        .hi_seven_o  (hi_seven),
        .hi_double_o (hi_double)
    );

    sclgen_phase_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .en_i  (cnt_en),
        .cnt_o (cnt)
    );

    sclgen_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid_i),
        .cmd_op_i    (cmd_op_i),
        .cmd_bit_i   (cmd_bit_i),
        .scl_in_i    (scl_in_i),
        .cnt_i       (cnt),
        .lo_len_i    (lo_len),
        .lo_half_i   (lo_half),
        .hi_len_i    (hi_len),
        .hi_half_i   (hi_half),
        .hi_seven_i  (hi_seven),
        .hi_double_i (hi_double),
        .accept_o    (accept),
        .cnt_clr_o   (cnt_clr),
        .cnt_en_o    (cnt_en),
        .scl_o       (scl_o),
        .sda_o       (sda_o),
        .chg_o       (sda_chg_o),
        .smp_o       (sda_smp_o),
        .done_o      (done_o)
    );

    // R9: phase lengths only move on the cycle after an accepted command
    assert_div_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(lo_len) && $stable(hi_len)));

endmodule

// File: tb/sim_scl_timing_gen.sv
module sim_scl_timing_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] div_word = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        cmd_bit = 1'b0;
    logic        scl_hold = 1'b0;
    logic        scl_in;
    logic        scl_o, sda_o, sda_chg_o, sda_smp_o, done_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    int k_chg, k_smp, k_done, k_srise, k_sfall, k_drise, k_dfall;
    int n_chg, n_smp, n_done;

    always #10 clk = ~clk;   // 50 MHz

    assign scl_in = scl_o & ~scl_hold;

    scl_timing_gen u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .div_word_i  (div_word),
        .cmd_valid_i (cmd_valid),
        .cmd_op_i    (cmd_op),
        .cmd_bit_i   (cmd_bit),
        .scl_in_i    (scl_in),
        .scl_o       (scl_o),
        .sda_o       (sda_o),
        .sda_chg_o   (sda_chg_o),
        .sda_smp_o   (sda_smp_o),
        .done_o      (done_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Issue one command; index k counts edges after the accepting edge.
    task automatic run_cmd(input logic [1:0] op, input logic b, input int stretch,
                           input int inj_k, input logic [1:0] inj_op,
                           input int div_k, input logic [31:0] div_new, input int limit);
        logic ps, pd;
        ps = scl_o; pd = sda_o;
        k_chg = -1; k_smp = -1; k_done = -1;
        k_srise = -1; k_sfall = -1; k_drise = -1; k_dfall = -1;
        n_chg = 0; n_smp = 0; n_done = 0;
        cmd_valid = 1'b1; cmd_op = op; cmd_bit = b;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 0; k < limit; k++) begin
            if (sda_chg_o) begin n_chg++; if (k_chg < 0) k_chg = k; end
            if (sda_smp_o) begin n_smp++; if (k_smp < 0) k_smp = k; end
            if (done_o)    begin n_done++; if (k_done < 0) k_done = k; end
            if (scl_o && !ps && k_srise < 0) k_srise = k;
            if (!scl_o && ps && k_sfall < 0) k_sfall = k;
            if (sda_o && !pd && k_drise < 0) k_drise = k;
            if (!sda_o && pd && k_dfall < 0) k_dfall = k;
            ps = scl_o; pd = sda_o;
            scl_hold = (stretch > 0 && k_srise >= 0 && k < k_srise + stretch);
            if (k == inj_k) begin cmd_valid = 1'b1; cmd_op = inj_op; end
            else cmd_valid = 1'b0;
            if (k == div_k) div_word = div_new;
            @(negedge clk);
        end
        scl_hold = 1'b0;
        cmd_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "scl after reset", int'(scl_o), 1);
        chk("R1", "sda after reset", int'(sda_o), 1);
        chk("R1", "strobes after reset", int'({sda_chg_o, sda_smp_o, done_o}), 0);
    endtask

    task automatic t_idle_ignore;
        // BIT is not allowed while idle
        div_word = {16'd0, 16'd0};
        run_cmd(2'd1, 1'b0, 0, -1, 2'd0, -1, '0, 40);
        chk("R11", "done from BIT in idle", n_done, 0);
        chk("R11", "scl edge from BIT in idle", k_sfall, -1);
        chk("R11", "sda edge from BIT in idle", k_dfall, -1);
        chk("R1", "change strobes in idle", n_chg, 0);
    endtask

    task automatic t_start;
        div_word = {16'd2, 16'd1};          // HI=2, LO=1
        run_cmd(2'd0, 1'b0, 0, -1, 2'd0, -1, '0, 30);
        chk("R6", "sda fall on accept", k_dfall, 0);
        chk("R6", "scl fall after start hold", k_sfall, 24);
        chk("R12", "start done edge", k_done, 24);
        chk("R12", "start done count", n_done, 1);
    endtask

    task automatic t_bit_fields;
        // LO=1 -> 16 low clocks, HI=2 -> 24 high clocks
        run_cmd(2'd1, 1'b1, 0, -1, 2'd0, -1, '0, 46);
        chk("R4", "change strobe mid low", k_chg, 8);
        chk("R4", "sda follows bit at change", k_drise, 8);
        chk("R2", "low phase length", k_srise, 16);
        chk("R5", "sample strobe mid high", k_smp, 28);
        chk("R3", "high phase length", k_sfall - k_srise, 24);
        chk("R12", "bit done edge", k_done, 40);
        chk("R5", "one sample per bit", n_smp, 1);
    endtask

    task automatic t_bit_minimum;
        div_word = {16'd0, 16'd0};          // smallest phases: 8 and 8
        run_cmd(2'd1, 1'b0, 0, -1, 2'd0, -1, '0, 22);
        chk("R4", "sda falls to bit 0", k_dfall, 4);
        chk("R2", "minimum low length", k_srise, 8);
        chk("R5", "minimum sample point", k_smp, 12);
        chk("R3", "minimum done", k_done, 16);
    endtask

    task automatic t_busy_ignore;
        run_cmd(2'd1, 1'b1, 0, 5, 2'd3, -1, '0, 24);
        chk("R11", "stop while busy: done edge", k_done, 16);
        chk("R11", "stop while busy: one done", n_done, 1);
        chk("R11", "stop while busy: one change", n_chg, 1);
        chk("R11", "stop while busy: bus held low", int'(scl_o), 0);
    endtask

    task automatic t_div_change;
        div_word = {16'd1, 16'd2};          // low 24, high 16
        run_cmd(2'd1, 1'b0, 0, -1, 2'd0, 3, {16'd0, 16'd0}, 46);
        chk("R9", "low length keeps old word", k_srise, 24);
        chk("R9", "done keeps old word", k_done, 40);
        run_cmd(2'd1, 1'b1, 0, -1, 2'd0, -1, '0, 22);
        chk("R9", "next command uses new word", k_done, 16);
    endtask

    task automatic t_stretch;
        div_word = {16'd1, 16'd1};          // 16 and 16
        run_cmd(2'd1, 1'b0, 10, -1, 2'd0, -1, '0, 50);
        chk("R10", "rise unaffected", k_srise, 16);
        chk("R10", "sample delayed by stretch", k_smp, 34);
        chk("R10", "done delayed by stretch", k_done, 42);
    endtask

    task automatic t_restart;
        div_word = {16'd1, 16'd0};          // low 8, high 16
        run_cmd(2'd2, 1'b0, 0, -1, 2'd0, -1, '0, 46);
        chk("R7", "sda released mid low", k_drise, 4);
        chk("R7", "scl rises", k_srise, 8);
        chk("R7", "sda falls at 7/8 high", k_dfall, 22);
        chk("R7", "scl high twice the period", k_sfall, 40);
        chk("R12", "restart done edge", k_done, 40);
    endtask

    task automatic t_stop;
        div_word = {16'd0, 16'd0};
        run_cmd(2'd1, 1'b1, 0, -1, 2'd0, -1, '0, 20);
        div_word = {16'd1, 16'd0};          // low 8, high 16
        run_cmd(2'd3, 1'b0, 0, -1, 2'd0, -1, '0, 30);
        chk("R8", "sda driven low mid low", k_dfall, 4);
        chk("R8", "scl rises", k_srise, 8);
        chk("R8", "sda released at end", k_drise, 24);
        chk("R8", "done at end", k_done, 24);
        chk("R8", "scl stays high", k_sfall, -1);
        chk("R1", "idle scl", int'(scl_o), 1);
        chk("R1", "idle sda", int'(sda_o), 1);
    endtask

    task automatic t_held_start_ignore;
        div_word = {16'd0, 16'd0};
        run_cmd(2'd0, 1'b0, 0, -1, 2'd0, -1, '0, 20);     // open bus
        run_cmd(2'd0, 1'b0, 0, -1, 2'd0, -1, '0, 30);     // START while held
        chk("R11", "start while held: no done", n_done, 0);
        chk("R11", "start while held: scl stays low", k_srise, -1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_ignore();
        t_start();
        t_bit_fields();
        t_bit_minimum();
        t_busy_ignore();
        t_div_change();
        t_stretch();
        t_restart();
        t_stop();
        t_held_start_ignore();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R12: actual=hung expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule